// File: doc/BRIEF.md
# Read Strobe Sample Delay Control

This block sets where, after the read-enable strobe of a NAND flash interface, the read data is captured. A programmed delay factor moves the capture point in steps of one eighth of a reference period. The reference period is either a full bus clock period or half of one. The block keeps the factor, a half-period select and an enable. It produces a ready flag once the delay path has had its lock time, and it emits the sample strobe, delayed or passed straight through.

The block runs on an oversampled clock, `OVERSAMPLE` ticks per bus clock period (16 by default). In full-period mode one eighth of a period is two ticks. In half-period mode it is one tick. The delay factor and the period select can only be reprogrammed while the delay is disabled. After the delay is enabled with a nonzero factor, `LOCK_CYCLES` bus periods (64 by default) must pass before it is used. Until then the raw strobe is forwarded and a flag reports that reads are happening unlocked. A factor of zero bypasses the delay path and is ready at once.

Top module: `rstrobe_delay_top`

## Requirements
- R1: After reset the delay is disabled, the factor is 0, full-period mode is selected, `delayReady` is 0, `unlockedUse` is 0 and `sampleStrobe` follows `rdStrobe` combinationally.
- R2: A configuration write (`cfgWe`=1 at a clock edge) made while the delay is disabled loads `cfgFactor`, `cfgHalf` and `cfgEnable` at that edge.
- R3: A configuration write made while the delay is enabled leaves the factor and the period select unchanged. Only its `cfgEnable` field takes effect, and rewriting enable as 1 does not restart the lock wait.
- R4: In full-period mode (`cfgHalf`=0), once ready, a one-tick pulse on `rdStrobe` appears on `sampleStrobe` exactly factor×OVERSAMPLE/8 ticks later, as a single one-tick pulse.
- R5: In half-period mode (`cfgHalf`=1), once ready, the delay is factor×OVERSAMPLE/16 ticks.
- R6: With a nonzero factor, `delayReady` is 0 for the first LOCK_CYCLES×OVERSAMPLE−1 clock edges after the enabling write edge. It becomes 1 after edge LOCK_CYCLES×OVERSAMPLE (1024 by default).
- R7: With factor 0 and the delay enabled, `delayReady` is 1 right after the enabling edge, and `sampleStrobe` equals `rdStrobe` undelayed.
- R8: A write with `cfgEnable`=0 drops `delayReady` at that same edge. A later enable starts the full lock wait again.
- R9: While `delayReady` is 0, `sampleStrobe` equals `rdStrobe`. `unlockedUse` is 1 exactly when `rdStrobe` is 1, the delay is enabled and not yet ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampled tick clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Configuration write strobe |
| cfgFactor | input | 4 | Delay factor in eighths of the reference period |
| cfgHalf | input | 1 | 1 selects a half bus period as the reference |
| cfgEnable | input | 1 | Delay enable |
| rdStrobe | input | 1 | Raw read-enable sample pulse |
| sampleStrobe | output | 1 | Delayed, or passed-through, sample strobe |
| delayReady | output | 1 | Delay locked and in use |
| unlockedUse | output | 1 | Strobe seen while enabled but not yet locked |

## Verification
A table of factor and period-select pairs is run through. It covers the smallest and largest factors in both modes, a mid value in each mode, and factor 0 in both modes. The table separates a doubled step from a single one, an off-by-one tap from the right tap, and a bypassed path from a delayed one. For every nonzero entry, ready is sampled on the edge before and on the edge of lock expiry, which pins the lock length exactly. A strobe fired during the wait shows the pass-through and the unlocked flag. Directed cases then rewrite the configuration while enabled, and disable it, to show that the factor is held and that ready falls at once.

// File: rtl/rstrobe_pkg.sv
package rstrobe_pkg;
  // Width of the programmable delay factor
  parameter int FACTOR_W = 4;
  // Oversampled ticks per bus clock period (multiple of 16)
  parameter int OVERSAMPLE = 16;
  // Ticks per eighth of a full and of a half period
  parameter int STEP_FULL = OVERSAMPLE / 8;
  parameter int STEP_HALF = OVERSAMPLE / 16;
  // Longest delay in ticks and the width to hold it
  parameter int MAX_TAPS = ((1 << FACTOR_W) - 1) * STEP_FULL;
  parameter int TAP_W = $clog2(MAX_TAPS + 1);

  // Strobes and settings the control hands to the delay line
  typedef struct packed {
    logic             enabled;
    logic             ready;
    logic             useDelay;
    logic [TAP_W-1:0] delayTicks;
  } dlyCtrl_t;
endpackage

// File: rtl/rstrobe_ctrl.sv
module rstrobe_ctrl
  import rstrobe_pkg::*;
#(
  parameter int LOCK_CYCLES = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [FACTOR_W-1:0] cfgFactor,
  input  logic                cfgHalf,
  input  logic                cfgEnable,
  output dlyCtrl_t            ctrlBus
);
  localparam int LOCK_TICKS = LOCK_CYCLES * OVERSAMPLE;
  localparam int CNT_W = $clog2(LOCK_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(LOCK_TICKS);
  localparam logic [TAP_W-1:0] MUL_FULL = TAP_W'(STEP_FULL);
  localparam logic [TAP_W-1:0] MUL_HALF = TAP_W'(STEP_HALF);

  logic                enReg;
  logic                halfReg;
  logic [FACTOR_W-1:0] factorReg;
  logic [CNT_W-1:0]    lockCnt;
  logic [TAP_W-1:0]    ticks;
  logic                locked;

  // Settings: factor and period select only move while disabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg     <= 1'b0;
      halfReg   <= 1'b0;
      factorReg <= '0;
    end else if (cfgWe) begin
      enReg <= cfgEnable;
      if (!enReg) begin
        factorReg <= cfgFactor;
        halfReg   <= cfgHalf;
      end
    end
  end

  // Lock timer: restarts whenever the delay is disabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockCnt <= '0;
    end else if (!enReg) begin
      lockCnt <= '0;
    end else if (lockCnt != CNT_DONE) begin
      lockCnt <= lockCnt + 1'b1;
    end
  end

  always_comb begin
    ticks  = TAP_W'(factorReg) * (halfReg ? MUL_HALF : MUL_FULL);
    locked = (lockCnt == CNT_DONE);
    ctrlBus.enabled    = enReg;
    ctrlBus.ready      = enReg && ((ticks == '0) || locked);
    ctrlBus.useDelay   = enReg && locked && (ticks != '0);
    ctrlBus.delayTicks = ticks;
  end
endmodule

// File: rtl/rstrobe_dline.sv
module rstrobe_dline
  import rstrobe_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  dlyCtrl_t ctrlBus,
  input  logic     rdStrobe,
  output logic     sampleStrobe,
  output logic     unlockedUse
);
  logic [MAX_TAPS-1:0] line;
  logic                tapOut;

  // Tick-rate shift line, one stage per tick of delay
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      line <= '0;
    end else begin
      line <= {line[MAX_TAPS-2:0], rdStrobe};
    end
  end

  // Tap select: stage i carries the strobe i+1 ticks late
  always_comb begin
    tapOut = 1'b0;
    for (int i = 0; i < MAX_TAPS; i++) begin
      if (ctrlBus.delayTicks == TAP_W'(i + 1)) tapOut = line[i];
    end
  end

  assign sampleStrobe = ctrlBus.useDelay ? tapOut : rdStrobe;
  assign unlockedUse  = rdStrobe && ctrlBus.enabled && !ctrlBus.ready;
endmodule

// File: rtl/rstrobe_delay_top.sv
module rstrobe_delay_top
  import rstrobe_pkg::*;
#(
  parameter int LOCK_CYCLES = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [FACTOR_W-1:0] cfgFactor,
  input  logic                cfgHalf,
  input  logic                cfgEnable,
  input  logic                rdStrobe,
  output logic                sampleStrobe,
  output logic                delayReady,
  output logic                unlockedUse
);
  dlyCtrl_t ctrlBus;

  rstrobe_ctrl #(.LOCK_CYCLES(LOCK_CYCLES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgFactor (cfgFactor),
    .cfgHalf   (cfgHalf),
    .cfgEnable (cfgEnable),
    .ctrlBus   (ctrlBus)
  );

  rstrobe_dline u_dline (
    .clk          (clk),
    .rstN         (rstN),
    .ctrlBus      (ctrlBus),
    .rdStrobe     (rdStrobe),
    .sampleStrobe (sampleStrobe),
    .unlockedUse  (unlockedUse)
  );

  assign delayReady = ctrlBus.ready;
endmodule

// File: rtl/rstrobe_chk.sv
module rstrobe_chk
  import rstrobe_pkg::*;
#(
  parameter int LOCK_CYCLES = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWe,
  input logic             cfgEnable,
  input logic             rdStrobe,
  input logic             sampleStrobe,
  input logic             delayReady,
  input logic             unlockedUse,
  input logic             enabled,
  input logic [TAP_W-1:0] delayTicks
);
  localparam int LOCK_TICKS = LOCK_CYCLES * OVERSAMPLE;
  localparam int CW = $clog2(LOCK_TICKS + 2);

  // Independent count of edges spent enabled
  logic [CW-1:0] sinceEn;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceEn <= '0;
    else if (!enabled) sinceEn <= '0;
    else if (sinceEn < CW'(LOCK_TICKS + 1)) sinceEn <= sinceEn + 1'b1;
  end

  always @(posedge clk) begin
    if (!rstN) assert_reset_idle_R1: assert (!delayReady);
  end

  assert_hold_while_on_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enabled) && enabled) |-> $stable(delayTicks));

  assert_one_tick_delay_R5: assert property (@(posedge clk) disable iff (!rstN)
    (delayReady && delayTicks == TAP_W'(1) && $past(delayReady) && $stable(delayTicks))
      |-> (sampleStrobe == $past(rdStrobe)));

  assert_lock_time_R6: assert property (@(posedge clk) disable iff (!rstN)
    (delayReady && delayTicks != '0) |-> (sinceEn >= CW'(LOCK_TICKS)));

  assert_bypass_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (enabled && delayTicks == '0) |-> (delayReady && sampleStrobe == rdStrobe));

  assert_drop_on_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWe && !cfgEnable) |-> !delayReady);

  assert_pass_unready_R9: assert property (@(posedge clk) disable iff (!rstN)
    !delayReady |-> (sampleStrobe == rdStrobe));

  assert_flag_unready_R9: assert property (@(posedge clk) disable iff (!rstN)
    unlockedUse |-> (!delayReady && sampleStrobe));
endmodule

bind rstrobe_delay_top rstrobe_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cfgWe        (cfgWe),
  .cfgEnable    (cfgEnable),
  .rdStrobe     (rdStrobe),
  .sampleStrobe (sampleStrobe),
  .delayReady   (delayReady),
  .unlockedUse  (unlockedUse),
  .enabled      (ctrlBus.enabled),
  .delayTicks   (ctrlBus.delayTicks)
);

// File: tb/tb_rstrobe_delay_top.sv
`timescale 1ns/1ps
module tb_rstrobe_delay_top;
  localparam int LOCK_T = 64 * 16;
  localparam int NV = 9;
  localparam int VF[NV] = '{1, 1, 7, 15, 15, 8, 3, 0, 0};
  localparam int VH[NV] = '{0, 1, 0, 0, 1, 1, 0, 0, 1};
  localparam int VD[NV] = '{2, 1, 14, 30, 15, 8, 6, 0, 0};

  logic clk = 0, rstN = 0, cfgWe = 0, cfgHalf = 0, cfgEnable = 0, rdStrobe = 0;
  logic [3:0] cfgFactor = '0;
  logic sampleStrobe, delayReady, unlockedUse;
  int checks = 0, errors = 0;
  bit done = 0;

  rstrobe_delay_top dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgFactor(cfgFactor),
    .cfgHalf(cfgHalf), .cfgEnable(cfgEnable), .rdStrobe(rdStrobe),
    .sampleStrobe(sampleStrobe), .delayReady(delayReady), .unlockedUse(unlockedUse)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input int f, input int h, input int e);
    @(negedge clk);
    cfgWe = 1; cfgFactor = 4'(f); cfgHalf = h[0]; cfgEnable = e[0];
    @(negedge clk);
    cfgWe = 0;
  endtask

  // Fire one-tick pulse, report first tick it shows and pulse count
  task automatic measure(output int first, output int ones);
    first = -1; ones = 0;
    @(negedge clk); rdStrobe = 1; #1;
    if (sampleStrobe) begin first = 0; ones++; end
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk); rdStrobe = 0; #1;
      if (sampleStrobe) begin if (first < 0) first = k; ones++; end
    end
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish();
  end

  initial begin
    int first, ones;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(delayReady == 0, "R1 ready", delayReady, 0);
    check(unlockedUse == 0, "R1 unlocked", unlockedUse, 0);
    rdStrobe = 1; #1;
    check(sampleStrobe == 1, "R1 passthrough", sampleStrobe, 1);
    @(negedge clk); rdStrobe = 0;
    rstN = 1;
    @(negedge clk);
    check(delayReady == 0, "R1 ready after release", delayReady, 0);

    for (int v = 0; v < NV; v++) begin
      cfgWrite(0, 0, 0);
      check(delayReady == 0, "R8 off", delayReady, 0);
      cfgWrite(VF[v], VH[v], 1);  // R2 load while disabled
      if (VD[v] == 0) begin
        check(delayReady == 1, "R7 ready at once", delayReady, 1);
        measure(first, ones);
        check(first == 0 && ones == 1, "R7 bypass", first, 0);
      end else begin
        rdStrobe = 1; #1;
        check(sampleStrobe == 1, "R9 passthrough", sampleStrobe, 1);
        check(unlockedUse == 1, "R9 unlocked flag", unlockedUse, 1);
        for (int k = 1; k < LOCK_T; k++) begin
          @(negedge clk);
          if (k == 1) rdStrobe = 0;
        end
        check(delayReady == 0, "R6 not yet", delayReady, 0);
        @(negedge clk);
        check(delayReady == 1, "R6 locked", delayReady, 1);
        measure(first, ones);
        if (VH[v] != 0) check(first == VD[v], "R5 half delay", first, VD[v]);
        else            check(first == VD[v], "R4 full delay", first, VD[v]);
        check(ones == 1, "R4 single pulse", ones, 1);
      end
    end

    // R3: rewrite while enabled is ignored, no relock
    cfgWrite(0, 0, 0);
    cfgWrite(4, 0, 1);
    repeat (LOCK_T) @(negedge clk);
    check(delayReady == 1, "R6 locked f4", delayReady, 1);
    cfgWrite(9, 1, 1);
    check(delayReady == 1, "R3 no relock", delayReady, 1);
    measure(first, ones);
    check(first == 8, "R3 factor held", first, 8);
    // R8 disable drops ready at the write edge, passthrough again
    @(negedge clk);
    cfgWe = 1; cfgEnable = 0; cfgFactor = 4'd2;
    @(posedge clk); #1;
    check(delayReady == 0, "R8 drop same edge", delayReady, 0);
    @(negedge clk); cfgWe = 0;
    measure(first, ones);
    check(first == 0, "R8 passthrough", first, 0);
    check(unlockedUse == 0, "R9 no flag when off", unlockedUse, 0);
    finish();
  end
endmodule